// File: doc/BRIEF.md
# Flash Query and Identification Read Responder

This block forms the read data of a parallel NOR flash front end whenever that front end is in one of its non-array read modes. The front end's command decoder selects the mode. The responder then answers each read strobe with a 32-bit word. The bus behaves as if two 16-bit flash chips sat side by side on it.

Three modes produce data:
- **Query mode** returns one byte of a fixed self-description table, indexed by the byte address divided by four. The size and erase-geometry fields of that table are computed from parameters rather than stored.
- **Identification mode** returns a vendor code, a device code, or the lock state of the erase block the address falls in. The lock state is obtained through a lookup port that the owner of the lock bitmap answers in the same cycle.
- **Status mode** returns the status byte supplied by the front end.

The 16-bit result is shaped to the access size. A word access gets it in both halves, a half-word access gets it once, and a byte access gets its low byte. The result is registered, so it appears one cycle after the strobe.

Top module: `flqr_top`

## Requirements
- R1: While reset is asserted and after its release with no strobe, `rvld_o` is 0 and `rdata_o` is 0.
- R2: `rvld_o` is 1 exactly in the cycle after a cycle with `rd_stb_i` high. `rdata_o` changes only in the cycle after a strobe and otherwise holds its value.
- R3: In query mode (`mode_i`=3) the table index is `addr_i`/4, so address bits 1:0 have no effect. The fixed fields read as follows:
  - indices 0x10..0x12 give 0x51, 0x52, 0x59;
  - indices 0x31..0x35 give 0x50, 0x52, 0x49, 0x31, 0x30;
  - index 0x28 gives 0x05, index 0x2A gives 0x06 (buffer log2 7 + 1 − 2), index 0x2C gives 0x01.
- R4: Query geometry fields:
  - index 0x27 gives log2 of one chip's size, ADDR_W−1;
  - indices 0x2D/0x2E give the erase block count (2^(ADDR_W−16)) minus one, low byte first;
  - indices 0x2F/0x30 give the per-chip block size in 256-byte units (0x80, 0x00).
- R5: Query indices 0x00..0x0F and every index from 0x44 upward read as zero.
- R6: In identification mode (`mode_i`=2) the index is (`addr_i` & 0x7FF)/4. Index 0 gives 0x0000, index 1 gives 0xFFFF, and every index other than 0, 1 and 2 gives 0.
- R7: Identification index 2 gives the lock bit (0 or 1) of the block `addr_i`>>16, which is presented on `lk_block_o`.
- R8: In status mode (`mode_i`=1) the 16-bit value is `status_i` zero-extended.
- R9: Lane shaping by `size_i`:
  - 0 (byte) gives the low byte with bits 31:8 zero;
  - 1 (half) gives the 16-bit value with bits 31:16 zero;
  - 2 and 3 (word) give the 16-bit value in both halves.
- R10: In array mode (`mode_i`=0) the response is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb_i | input | 1 | Read strobe, one cycle per access |
| mode_i | input | 2 | Read mode: 0 array, 1 status, 2 identification, 3 query |
| addr_i | input | ADDR_W | Byte address within the device |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| status_i | input | 8 | Current status byte |
| lk_block_o | output | ADDR_W−16 | Erase block index for the lock lookup |
| lk_locked_i | input | 1 | Lock state of the block on `lk_block_o` |
| rvld_o | output | 1 | Response valid, one cycle after the strobe |
| rdata_o | output | 32 | Response data |

## Verification
The query table is swept over every index from 0 to 0x4F at word size, and again with nonzero low address bits. This separates correct divide-by-four indexing from off-by-one or mis-shifted decoding, and a stored geometry value from one computed wrongly. Identification reads run over the first sixteen indices in a locked and an unlocked block, and with address bits above bit 10 set. These reads tell whether the lock bit, the vendor and device codes and the 0x7FF masking are each honoured. Status and identification values are read at all four sizes to expose a wrong mirror or a missing lane clear, and array mode and idle cycles show the output stays zero or held.

// File: rtl/flqr_pkg.sv
package flqr_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // number of meaningful query table bytes
  localparam int unsigned QRY_TABLE_LEN = 68;

endpackage

// File: rtl/flqr_qry_rom.sv
module flqr_qry_rom #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned BLK_LOG2 = 16,
  parameter int unsigned BUF_LOG2 = 7
) (
  input  logic [ADDR_W-1:0] idx_i,
  output logic [7:0]        byte_o
);
  import flqr_pkg::*;

  localparam logic [7:0]  CHIP_LOG2 = 8'(ADDR_W - 1);
  localparam logic [31:0] NBLK_M1   = 32'((1 << (ADDR_W - BLK_LOG2)) - 1);
  localparam logic [31:0] EB_UNITS  = 32'(1 << (BLK_LOG2 - 1 - 8));
  localparam logic [7:0]  BUF_FLD   = 8'(BUF_LOG2 + 1 - 2);

  logic in_tab;

  always_comb begin
    in_tab = (idx_i < ADDR_W'(QRY_TABLE_LEN));
    byte_o = 8'h00;
    if (in_tab) begin
      case (idx_i[6:0])
        7'h10: byte_o = 8'h51;
        7'h11: byte_o = 8'h52;
        7'h12: byte_o = 8'h59;
        7'h13: byte_o = 8'h01;
        7'h15: byte_o = 8'h31;
        7'h1b: byte_o = 8'h45;
        7'h1c: byte_o = 8'h55;
        7'h1f: byte_o = 8'h01;
        7'h20: byte_o = 8'h01;
        7'h21: byte_o = 8'h01;
        7'h27: byte_o = CHIP_LOG2;
        7'h28: byte_o = 8'h05;
        7'h2a: byte_o = BUF_FLD;
        7'h2c: byte_o = 8'h01;
        7'h2d: byte_o = NBLK_M1[7:0];
        7'h2e: byte_o = NBLK_M1[15:8];
        7'h2f: byte_o = EB_UNITS[7:0];
        7'h30: byte_o = EB_UNITS[15:8];
        7'h31: byte_o = 8'h50;
        7'h32: byte_o = 8'h52;
        7'h33: byte_o = 8'h49;
        7'h34: byte_o = 8'h31;
        7'h35: byte_o = 8'h30;
        7'h36: byte_o = 8'ha0;
        7'h3b: byte_o = 8'h01;
        7'h3d: byte_o = 8'h50;
        7'h3f: byte_o = 8'h01;
        default: byte_o = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/flqr_id_dec.sv
module flqr_id_dec (
  input  logic [8:0]  idx_i,
  input  logic        locked_i,
  output logic [15:0] val_o
);

  always_comb begin
    case (idx_i)
      9'd0:    val_o = 16'h0000;
      9'd1:    val_o = 16'hffff;
      9'd2:    val_o = {15'd0, locked_i};
      default: val_o = 16'h0000;
    endcase
  end

endmodule

// File: rtl/flqr_lane_pack.sv
module flqr_lane_pack (
  input  logic [15:0] val_i,
  input  logic [1:0]  size_i,
  output logic [31:0] word_o
);
  import flqr_pkg::*;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: word_o = {24'd0, val_i[7:0]};
      SZ_HALF: word_o = {16'd0, val_i};
      default: word_o = {val_i, val_i};
    endcase
  end

endmodule

// File: rtl/flqr_top.sv
module flqr_top #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned BLK_LOG2 = 16,
  parameter int unsigned BUF_LOG2 = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_stb_i,
  input  logic [1:0]                 mode_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [1:0]                 size_i,
  input  logic [7:0]                 status_i,
  output logic [ADDR_W-BLK_LOG2-1:0] lk_block_o,
  input  logic                       lk_locked_i,
  output logic                       rvld_o,
  output logic [31:0]                rdata_o
);
  import flqr_pkg::*;

  logic [ADDR_W-1:0] qry_idx;
  logic [7:0]        qry_byte;
  logic [15:0]       id_val;
  logic [15:0]       sel_val;
  logic [31:0]       packed_w;
  logic [31:0]       data_d, data_q;
  logic              vld_d, vld_q;

  assign qry_idx    = addr_i >> 2;
  assign lk_block_o = addr_i[ADDR_W-1:BLK_LOG2];

  flqr_qry_rom #(
    .ADDR_W  (ADDR_W),
    .BLK_LOG2(BLK_LOG2),
    .BUF_LOG2(BUF_LOG2)
  ) u_qry (
    .idx_i (qry_idx),
    .byte_o(qry_byte)
  );

  flqr_id_dec u_id (
    .idx_i   (addr_i[10:2]),
    .locked_i(lk_locked_i),
    .val_o   (id_val)
  );

  always_comb begin
    case (rd_mode_e'(mode_i))
      RM_STATUS: sel_val = {8'd0, status_i};
      RM_IDENT:  sel_val = id_val;
      RM_QUERY:  sel_val = {8'd0, qry_byte};
      default:   sel_val = 16'd0;
    endcase
  end

  flqr_lane_pack u_pack (
    .val_i (sel_val),
    .size_i(size_i),
    .word_o(packed_w)
  );

  // next state
  always_comb begin
    vld_d  = rd_stb_i;
    data_d = data_q;
    if (rd_stb_i) data_d = packed_w;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= 32'd0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign rvld_o  = vld_q;
  assign rdata_o = data_q;

  assert_vld_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rvld_o);
  assert_no_spurious_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> !rvld_o);
  assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rdata_o));
  assert_byte_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'd0));
  assert_half_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && size_i == 2'd1) |=> (rdata_o[31:16] == 16'd0));
  assert_word_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && size_i[1]) |=> (rdata_o[31:16] == rdata_o[15:0]));
  assert_array_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && mode_i == 2'd0) |=> (rdata_o == 32'd0));
  assert_status_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && mode_i == 2'd1 && size_i == 2'd1) |=> (rdata_o[15:8] == 8'd0));

endmodule

// File: tb/tb_flqr_top.sv
`timescale 1ns/1ps
module tb_flqr_top;
  localparam int ADDR_W = 24;
  localparam int NBLK   = 1 << (ADDR_W - 16);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_stb;
  logic [1:0]        mode;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        size;
  logic [7:0]        status;
  logic [ADDR_W-17:0] lk_block;
  logic              lk_locked;
  logic              rvld;
  logic [31:0]       rdata;
  logic [NBLK-1:0]   lockmap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign lk_locked = lockmap[lk_block];

  flqr_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .rd_stb_i(rd_stb), .mode_i(mode),
    .addr_i(addr), .size_i(size), .status_i(status),
    .lk_block_o(lk_block), .lk_locked_i(lk_locked),
    .rvld_o(rvld), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] shape(input logic [15:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return {24'd0, v[7:0]};
    if (sz == 2'd1) return {16'd0, v};
    return {v, v};
  endfunction

  // expected query byte from the requirements; -1 where unspecified
  function automatic int qexp(input int idx);
    case (idx)
      'h10: return 'h51;  'h11: return 'h52;  'h12: return 'h59;
      'h31: return 'h50;  'h32: return 'h52;  'h33: return 'h49;
      'h34: return 'h31;  'h35: return 'h30;
      'h28: return 'h05;  'h2a: return 7 + 1 - 2;  'h2c: return 'h01;
      'h27: return ADDR_W - 1;
      'h2d: return (NBLK - 1) & 'hff;
      'h2e: return ((NBLK - 1) >> 8) & 'hff;
      'h2f: return ((1 << 15) / 256) & 'hff;
      'h30: return (((1 << 15) / 256) >> 8) & 'hff;
      default: begin
        if (idx < 'h10 || idx >= 'h44) return 0;
        return -1;
      end
    endcase
  endfunction

  // one access: drive at negedge, strobe one cycle, sample at following negedge
  task automatic rd(input logic [1:0] m, input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    @(negedge clk);
    mode = m; addr = a; size = sz; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R2 valid after strobe", {31'd0, rvld}, 32'd1);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_stb = 1'b0; mode = 2'd0; addr = '0; size = 2'd2;
    status = 8'h80; lockmap = '0;
    lockmap[5] = 1'b1;
    lockmap[NBLK-1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, rvld}, 32'd0);
    chk("R1 reset data", rdata, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle valid", {31'd0, rvld}, 32'd0);
    chk("R1 idle data", rdata, 32'd0);

    // R3 R4 R5: query sweep, word size, with and without low address bits
    for (int i = 0; i < 'h50; i++) begin
      int e;
      e = qexp(i);
      rd(2'd3, ADDR_W'(i * 4), 2'd2);
      if (e >= 0) chk($sformatf("R3/R4/R5 query idx %0h", i), rdata, shape(16'(e), 2'd2));
      rd(2'd3, ADDR_W'(i * 4 + 3), 2'd1);
      if (e >= 0) chk($sformatf("R3 query low bits idx %0h", i), rdata, shape(16'(e), 2'd1));
    end
    rd(2'd3, ADDR_W'('h3ffff0), 2'd2);
    chk("R5 query far index", rdata, 32'd0);

    // R2 hold: idle cycle, data unchanged and valid low
    rd(2'd3, ADDR_W'('h10 * 4), 2'd2);
    @(negedge clk);
    chk("R2 no valid when idle", {31'd0, rvld}, 32'd0);
    chk("R2 data held", rdata, 32'h00510051);

    // R6 R7: identification in unlocked block 0, locked block 5, alias above bit 10
    for (int b = 0; b < 2; b++) begin
      int blk;
      blk = (b == 0) ? 0 : 5;
      for (int i = 0; i < 16; i++) begin
        logic [15:0] e;
        e = (i == 1) ? 16'hffff : (i == 2) ? 16'(lockmap[blk]) : 16'h0000;
        rd(2'd2, ADDR_W'(blk * 65536 + i * 4 + 1), 2'd2);
        chk($sformatf("R6/R7 ident blk %0d idx %0d", blk, i), rdata, shape(e, 2'd2));
        rd(2'd2, ADDR_W'(blk * 65536 + 'h800 + i * 4), 2'd2);
        chk($sformatf("R6 ident alias blk %0d idx %0d", blk, i), rdata, shape(e, 2'd2));
      end
    end
    rd(2'd2, ADDR_W'((NBLK - 1) * 65536 + 8), 2'd1);
    chk("R7 last block locked", rdata, 32'h00000001);
    chk("R7 lookup block index", 32'(lk_block), 32'(NBLK - 1));

    // R8 R9: status and ident values at every size
    for (int s = 0; s < 4; s++) begin
      status = 8'hb2;
      rd(2'd1, ADDR_W'('h1234), 2'(s));
      chk($sformatf("R8/R9 status size %0d", s), rdata, shape(16'h00b2, 2'(s)));
      rd(2'd2, ADDR_W'(4), 2'(s));
      chk($sformatf("R9 ident dev size %0d", s), rdata, shape(16'hffff, 2'(s)));
      rd(2'd3, ADDR_W'('h27 * 4), 2'(s));
      chk($sformatf("R9 query size %0d", s), rdata, shape(16'(ADDR_W - 1), 2'(s)));
    end

    // R10: array mode gives zero
    rd(2'd0, ADDR_W'(4), 2'd2);
    chk("R10 array mode zero", rdata, 32'd0);
    rd(2'd0, ADDR_W'('h44), 2'd0);
    chk("R10 array mode byte zero", rdata, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule